// File: doc/BRIEF.md
# Clock Configuration Register Bank

This block holds the control state of a multi-output system clock generator. A byte-wide serial-slave front end reaches it through a byte index, a write strobe, write data and a combinational read-data return. The serial protocol engine, the PLLs and the spread modulator sit outside the block and consume its outputs.

On the first rising clock edge after reset is released, the block samples four frequency-select pins and stores their logical inverse. A 4-bit effective frequency code is then taken either from that captured value or from a field spread over control byte 0. A lookup on the effective code tells the downstream divider whether the PCI clock runs at one half or one third of the CPU clock.

Control byte 0 also carries the spread-spectrum enable and type and a global output tristate. Bytes 1 to 3 are per-output enable masks. Reserved bits read back as 1, read-only bits report captured pin state, and indices above 3 are dead. Until byte 0 has been written once, its frequency field reads back as a fixed revision code.

Top module: `clkcfg_bank`

## Requirements
- R1: After reset, the block holds its defaults: byte 0 stores 0x02, bytes 1 to 3 store all ones apart from their read-only bits, spread_en_o is 1, spread_down_o is 0, tristate_o is 0 and every enable output is 1.
- R2: On the first rising clock edge after rst_ni goes high, the captured code takes the bitwise inverse of fs_pins_i (bit 3 = FS3 ... bit 0 = FS0). Later changes of fs_pins_i have no effect until the next reset.
- R3: When byte 0 bit 3 is 0, freq_code_o equals the captured code. When it is 1, freq_code_o is {byte0[2], byte0[6], byte0[5], byte0[4]}, with byte0[2] as the most significant bit.
- R4: spread_en_o follows byte 0 bit 1. spread_down_o is byte 0 bit 7 (1 = down spread, 0 = center spread) while bit 1 is 1, and it is forced to 0 while bit 1 is 0.
- R5: tristate_o follows byte 0 bit 0.
- R6: Until byte 0 is first written after reset, a read of byte 0 returns REV_ID in bits {2,6,5,4} (REV_ID[3] in bit 2, then bits 6, 5, 4). The other bits return the stored value. After the first write, all stored bits are returned.
- R7: Enable outputs map as follows: cpu_en_o[3:0] = byte1 bits {6,2,1,0}, sdram_free_en_o = byte1 bit 3, pci_en_o[5] = byte2 bit 6, pci_en_o[4:0] = byte2 bits 4:0, and sdram_en_o[7:0] = byte3. A 1 enables the output.
- R8: Reserved bits (byte 1 bits 5:4 and byte 2 bit 5) always read as 1, and writes to them are ignored.
- R9: Byte 1 bit 7 reads the captured FS2 (captured code bit 2), and byte 2 bit 7 reads the captured FS0 (captured code bit 0). Writes to these bits are ignored.
- R10: pci_div3_o is 1 for effective codes 0 to 4 and 8 to 12, and 0 for codes 5 to 7 and 13 to 15.
- R11: A read at an index above 3 returns 0, and a write there changes no state.
- R12: A write with wr_en_i high is stored on the rising clock edge, and the outputs reflect it after that edge. rdata_o is combinational from addr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fs_pins_i | input | 4 | Frequency-select pin levels |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | ADDR_W (3) | Byte index |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| freq_code_o | output | 4 | Effective frequency code |
| pci_div3_o | output | 1 | 1 = PCI is CPU/3, 0 = CPU/2 |
| spread_en_o | output | 1 | Spread spectrum enable |
| spread_down_o | output | 1 | 1 = down spread, 0 = center spread |
| tristate_o | output | 1 | Tristate all clock outputs |
| cpu_en_o | output | 4 | CPU clock enables |
| sdram_free_en_o | output | 1 | Free-running SDRAM clock enable |
| sdram_en_o | output | 8 | SDRAM clock enables |
| pci_en_o | output | 6 | PCI clock enables |

## Verification
The assertions assume that fs_pins_i holds still around the first clock edge after reset release. They also assume that wr_en_i, addr_i and wdata_i are stable at each rising edge. The bench sets the pins while reset is asserted and changes them only after capture. It drives every bus input on the falling edge and samples the outputs one time unit after a falling edge, so no check sits on the edge where the data is taken.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  localparam int NUM_BYTES = 4;
  localparam int DATA_W    = 8;
  localparam int CODE_W    = 4;

  // byte 0 control bit positions
  localparam int B0_DOWN = 7;
  localparam int B0_SRC  = 3;
  localparam int B0_SSEN = 1;
  localparam int B0_TRI  = 0;
  localparam int RO_BIT  = 7;

  function automatic logic [DATA_W-1:0] rst_val(input int idx);
    case (idx)
      0:       return 8'h02;
      1:       return 8'h7F;
      2:       return 8'h7F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] wr_mask(input int idx);
    case (idx)
      0:       return 8'hFF;
      1:       return 8'b0100_1111;
      2:       return 8'b0101_1111;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] ro_mask(input int idx);
    return (idx == 1 || idx == 2) ? 8'h80 : 8'h00;
  endfunction

  function automatic logic [CODE_W-1:0] field_get(input logic [DATA_W-1:0] b);
    return {b[2], b[6], b[5], b[4]};
  endfunction

  function automatic logic [DATA_W-1:0] field_put(input logic [DATA_W-1:0] b,
                                                  input logic [CODE_W-1:0] c);
    logic [DATA_W-1:0] r;
    r    = b;
    r[2] = c[3];
    r[6] = c[2];
    r[5] = c[1];
    r[4] = c[0];
    return r;
  endfunction
endpackage

// File: rtl/clkcfg_fs_capture.sv
module clkcfg_fs_capture
  import clkcfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] fs_pins_i,
  output logic [CODE_W-1:0] fs_cap_o,
  output logic              cap_done_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_cap_o   <= '0;
      cap_done_o <= 1'b0;
    end else if (!cap_done_o) begin
      fs_cap_o   <= ~fs_pins_i;
      cap_done_o <= 1'b1;
    end
  end

  assert_capture_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_done_o |=> $stable(fs_cap_o));
endmodule

// File: rtl/clkcfg_regs.sv
module clkcfg_regs
  import clkcfg_pkg::*;
#(
  parameter int              ADDR_W = 3,
  parameter logic [CODE_W-1:0] REV_ID = 4'b0100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CODE_W-1:0] fs_cap_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [3:0]        cpu_en_o,
  output logic              sdram_free_en_o,
  output logic [5:0]        pci_en_o,
  output logic [7:0]        sdram_en_o
);
  logic [NUM_BYTES-1:0][DATA_W-1:0] reg_q;
  logic [NUM_BYTES-1:0][DATA_W-1:0] rd_view;
  logic                             wrote0_q;

  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
    localparam logic [DATA_W-1:0] RST = rst_val(i);
    localparam logic [DATA_W-1:0] WM  = wr_mask(i);
    localparam logic [DATA_W-1:0] RO  = ro_mask(i);
    logic hit;
    assign hit = wr_en_i && (addr_i == ADDR_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  reg_q[i] <= RST;
      else if (hit) reg_q[i] <= (reg_q[i] & ~WM) | (wdata_i & WM);
    end

    logic ro_src;
    if (i == 1) begin : g_fs2
      assign ro_src = fs_cap_i[2];
    end else if (i == 2) begin : g_fs0
      assign ro_src = fs_cap_i[0];
    end else begin : g_none
      assign ro_src = 1'b0;
    end
    assign rd_view[i] = (reg_q[i] & ~RO) | ({DATA_W{ro_src}} & RO);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           wrote0_q <= 1'b0;
    else if (wr_en_i && addr_i == '0)      wrote0_q <= 1'b1;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == '0)
      rdata_o = wrote0_q ? rd_view[0] : field_put(rd_view[0], REV_ID);
    else if (32'(addr_i) < NUM_BYTES)
      rdata_o = rd_view[addr_i[1:0]];
  end

  assign ctrl_o          = reg_q[0];
  assign cpu_en_o        = {reg_q[1][6], reg_q[1][2:0]};
  assign sdram_free_en_o = reg_q[1][3];
  assign pci_en_o        = {reg_q[2][6], reg_q[2][4:0]};
  assign sdram_en_o      = reg_q[3];

  assert_reserved_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(1)) |=> (reg_q[1][5:4] == 2'b11));

  assert_oor_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && 32'(addr_i) >= NUM_BYTES) |=> $stable(reg_q));

  assert_write_lands_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(3)) |=> (sdram_en_o == $past(wdata_i)));
endmodule

// File: rtl/clkcfg_freq_sel.sv
module clkcfg_freq_sel
  import clkcfg_pkg::*;
#(
  parameter logic [(1<<CODE_W)-1:0] DIV3_MAP = 16'h1F1F
) (
  input  logic [CODE_W-1:0] fs_cap_i,
  input  logic [DATA_W-1:0] ctrl_i,
  output logic [CODE_W-1:0] code_o,
  output logic              div3_o
);
  assign code_o = ctrl_i[B0_SRC] ? field_get(ctrl_i) : fs_cap_i;
  assign div3_o = DIV3_MAP[code_o];
endmodule

// File: rtl/clkcfg_bank.sv
module clkcfg_bank
  import clkcfg_pkg::*;
#(
  parameter int                     ADDR_W   = 3,
  parameter logic [CODE_W-1:0]      REV_ID   = 4'b0100,
  parameter logic [(1<<CODE_W)-1:0] DIV3_MAP = 16'h1F1F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        fs_pins_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic [3:0]        freq_code_o,
  output logic              pci_div3_o,
  output logic              spread_en_o,
  output logic              spread_down_o,
  output logic              tristate_o,
  output logic [3:0]        cpu_en_o,
  output logic              sdram_free_en_o,
  output logic [7:0]        sdram_en_o,
  output logic [5:0]        pci_en_o
);
  logic [CODE_W-1:0] fs_cap;
  logic              cap_done;
  logic [DATA_W-1:0] ctrl;

  clkcfg_fs_capture u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fs_pins_i  (fs_pins_i),
    .fs_cap_o   (fs_cap),
    .cap_done_o (cap_done)
  );

  clkcfg_regs #(.ADDR_W(ADDR_W), .REV_ID(REV_ID)) u_regs (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .wr_en_i         (wr_en_i),
    .addr_i          (addr_i),
    .wdata_i         (wdata_i),
    .fs_cap_i        (fs_cap),
    .rdata_o         (rdata_o),
    .ctrl_o          (ctrl),
    .cpu_en_o        (cpu_en_o),
    .sdram_free_en_o (sdram_free_en_o),
    .pci_en_o        (pci_en_o),
    .sdram_en_o      (sdram_en_o)
  );

  clkcfg_freq_sel #(.DIV3_MAP(DIV3_MAP)) u_fsel (
    .fs_cap_i (fs_cap),
    .ctrl_i   (ctrl),
    .code_o   (freq_code_o),
    .div3_o   (pci_div3_o)
  );

  // down spread only legal while spreading
  assign spread_en_o   = ctrl[B0_SSEN];
  assign spread_down_o = ctrl[B0_DOWN] & ctrl[B0_SSEN];
  assign tristate_o    = ctrl[B0_TRI];

  assert_center_when_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == '0 && !wdata_i[B0_SSEN]) |=> !spread_down_o);

  assert_tristate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == '0) |=> (tristate_o == $past(wdata_i[B0_TRI])));

  assert_pin_src_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_done && $past(cap_done) && !ctrl[B0_SRC] && !$past(ctrl[B0_SRC]))
      |-> $stable(freq_code_o));

  assert_div_follows_code_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(freq_code_o) |-> $stable(pci_div3_o));
endmodule

// File: tb/clkcfg_bank_bench.sv
module clkcfg_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] DIV3_EXP = 16'h1F1F;
  localparam logic [3:0]  REV      = 4'b0100;

  logic       clk = 0;
  logic       rst_n = 0;
  logic [3:0] fs_pins = 4'b1110;
  logic       wr_en = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic [3:0] code;
  logic       div3, ss_en, ss_down, tri_st, sdf_en;
  logic [3:0] cpu_en;
  logic [7:0] sd_en;
  logic [5:0] pci_en;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkcfg_bank u_clkcfg_bank (
    .clk_i(clk), .rst_ni(rst_n), .fs_pins_i(fs_pins), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .freq_code_o(code),
    .pci_div3_o(div3), .spread_en_o(ss_en), .spread_down_o(ss_down),
    .tristate_o(tri_st), .cpu_en_o(cpu_en), .sdram_free_en_o(sdf_en),
    .sdram_en_o(sd_en), .pci_en_o(pci_en)
  );

  function automatic logic [7:0] put_code(input logic [7:0] b, input logic [3:0] c);
    logic [7:0] r = b;
    r[2] = c[3]; r[6] = c[2]; r[5] = c[1]; r[4] = c[0];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
    #1;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  // pins 1110 -> captured 0001
  task automatic t_reset_R1;
    logic [7:0] d;
    chk("R1 spread_en", ss_en, 1);
    chk("R1 spread_down", ss_down, 0);
    chk("R1 tristate", tri_st, 0);
    chk("R1 enables", {cpu_en, sdf_en, pci_en, sd_en}, {4'hF, 1'b1, 6'h3F, 8'hFF});
    chk("R2 captured code", code, 4'b0001);
    chk("R10 div3 code1", div3, 1);
    rd(3, d); chk("R1 byte3", d, 8'hFF);
  endtask

  task automatic t_capture_R2;
    logic [7:0] d;
    fs_pins = 4'b0000;
    repeat (3) @(negedge clk);
    #1;
    chk("R2 pins ignored after capture", code, 4'b0001);
    rd(1, d); chk("R9 byte1 FS2 readback", d, 8'h7F);
    rd(2, d); chk("R9 byte2 FS0 readback", d, 8'hFF);
  endtask

  task automatic t_revid_R6;
    logic [7:0] d;
    rd(0, d); chk("R6 revision id", d, put_code(8'h02, REV));
    wr(0, 8'h02);
    rd(0, d); chk("R6 readback after write", d, 8'h02);
  endtask

  task automatic t_code_src_R3;
    for (int c = 0; c < 16; c++) begin
      wr(0, put_code(8'h0A, 4'(c)));
      chk($sformatf("R3 reg code %0d", c), code, c);
      chk($sformatf("R10 div3 code %0d", c), div3, DIV3_EXP[c]);
    end
    wr(0, put_code(8'h02, 4'b1101));
    chk("R3 pin source ignores field", code, 4'b0001);
  endtask

  task automatic t_spread_R4;
    wr(0, 8'h82); chk("R4 down", {ss_en, ss_down}, 2'b11);
    wr(0, 8'h02); chk("R4 center", {ss_en, ss_down}, 2'b10);
    wr(0, 8'h80); chk("R4 forced center", {ss_en, ss_down}, 2'b00);
  endtask

  task automatic t_tristate_R5;
    wr(0, 8'h03); chk("R5 tristate on", tri_st, 1);
    wr(0, 8'h02); chk("R5 tristate off", tri_st, 0);
  endtask

  task automatic t_masks_R7;
    wr(1, 8'b0100_0101); chk("R7 cpu/sdram_f", {cpu_en, sdf_en}, {4'b1101, 1'b0});
    wr(2, 8'b0000_1010); chk("R7 pci", pci_en, 6'b001010);
    wr(3, 8'h5A);        chk("R7 sdram", sd_en, 8'h5A);
    chk("R12 write seen after edge", sd_en, 8'h5A);
  endtask

  task automatic t_reserved_R8_R9;
    logic [7:0] d;
    wr(1, 8'h00); rd(1, d); chk("R8 R9 byte1", d, 8'h30);
    wr(2, 8'h00); rd(2, d); chk("R8 R9 byte2", d, 8'hA0);
    wr(1, 8'hFF); rd(1, d); chk("R9 byte1 RO bit", d, 8'h7F);
    wr(2, 8'hFF);
  endtask

  task automatic t_oor_R11;
    logic [7:0] d;
    wr(4, 8'h00); wr(7, 8'h00);
    rd(5, d); chk("R11 read oor", d, 8'h00);
    chk("R11 no state change", {cpu_en, sdf_en, pci_en, sd_en, ss_en, tri_st},
        {4'hF, 1'b1, 6'h3F, 8'h5A, 1'b1, 1'b0});
    rd(3, d); chk("R11 byte3 intact", d, 8'h5A);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    #1;
    t_reset_R1();
    t_capture_R2();
    t_revid_R6();
    t_code_src_R3();
    t_spread_R4();
    t_tristate_R5();
    t_masks_R7();
    t_reserved_R8_R9();
    t_oor_R11();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule